// File: doc/BRIEF.md
# Pixel Run Copy and Fill Engine

This engine takes one command write and then rewrites a horizontal run of 1 to 32 eight-bit pixels in a framebuffer. It reaches the framebuffer through a single-port memory interface that makes one access per cycle. The command address gives the destination. The command data packs the run length and a source address into one word. When the source field holds the reserved all-ones value, the run is filled with the low byte of a foreground colour register. Any other source value makes the engine copy the run pixel by pixel from source to destination.

When deep-colour mode is in force as the command is taken, every write also goes to a 24-bit shadow plane through a second port that shares the pixel address. A fill writes the low 24 bits of the colour to that plane. A copy moves the plane words along with the pixels. The colour register is loaded through the same handshake as commands, with a selector bit. The engine lowers `cmd_ready` while a run is in progress, so the next write of either kind waits.

Top module: `pix_blit_engine`

## Requirements
- R1: After reset, `cmd_ready` is 1, `busy` is 0, and neither `mem_req` nor `pl_req` is asserted. Memory requests occur only while `busy` is 1.
- R2: The destination pixel index is `cmd_addr` shifted right by 3 and kept to its low ADDR_W (20) bits. The bits `cmd_addr[2:0]` and `cmd_addr[31:23]` have no effect.
- R3: The source index is `cmd_data[23:0]`, of which the low ADDR_W bits address memory. The run length is `cmd_data[28:24]` plus one. The bits `cmd_data[31:29]` and `cmd_data[63:32]` have no effect.
- R4: A source field equal to 24'hFFFFFF is a fill. It writes the colour register's bits [7:0] to the destination pixels in ascending order, one write per cycle. `busy` stays high for exactly the run length in cycles.
- R5: Any other source field is a copy. For each pixel in ascending order, the engine reads source+i in one cycle and writes that value to destination+i in the next. `busy` stays high for twice the run length. When the runs overlap, the result is the one this sequential order gives, so a destination one above the source replicates the first pixel. Addresses wrap modulo 2^ADDR_W.
- R6: In deep-colour mode, a fill also writes colour bits [23:0] to the shadow plane at each destination, and a copy also copies shadow-plane words. In 8-bit mode the shadow plane is never accessed.
- R7: `cmd_ready` is 0 whenever `busy` is 1. A write offered during a run, including a colour write, is held until the run ends. An accepted colour write (`cmd_is_colour`=1, value in `cmd_data[31:0]`) does not raise `busy`.
- R8: The colour register resets to zero, so a fill before any colour write stores zero.
- R9: `cmd_rdata` reads as zero at all times.
- R10: The `depth24` level is captured when a command is accepted. Changing it during a run does not alter that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command or colour write offered |
| cmd_ready | output | 1 | Engine can accept a write this cycle |
| cmd_is_colour | input | 1 | 1: load colour register, 0: run command |
| cmd_addr | input | 32 | Command byte address (destination) |
| cmd_data | input | 64 | Command data; 32- or 64-bit write, upper word ignored |
| cmd_rdata | output | 64 | Read data of the command port, always zero |
| depth24 | input | 1 | Deep-colour mode, sampled at command acceptance |
| busy | output | 1 | Run in progress |
| mem_req | output | 1 | Pixel memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 20 | Pixel index |
| mem_wdata | output | 8 | Pixel write data |
| mem_rdata | input | 8 | Pixel read data, valid the cycle after a read |
| pl_req | output | 1 | Shadow plane access at `mem_addr` |
| pl_we | output | 1 | Shadow plane access is a write |
| pl_wdata | output | 24 | Shadow plane write data |
| pl_rdata | input | 24 | Shadow plane read data, valid the cycle after a read |

## Verification
The hardest case to reach from the ports is a copy whose source and destination overlap. Here each write changes a pixel that a later read in the same run fetches, so the result shows whether reads and writes really alternate in ascending order. Directed commands place the destination one pixel above and one pixel below the source at full length. Random commands draw both indices from a small window so that overlaps recur. A colour write offered in the middle of a fill, and a `depth24` toggle during a run, cover the hold-off and capture rules.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int LEN_W = 5;
  localparam int SRC_W = 24;
  localparam logic [SRC_W-1:0] FILL_KEY = '1;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_RD, S_WR} seq_state_e;

  // pixel index carried by a command byte address
  function automatic logic [31:0] dst_index(input logic [31:0] a);
    return a >> 3;
  endfunction

  function automatic logic [SRC_W-1:0] src_field(input logic [31:0] d);
    return d[SRC_W-1:0];
  endfunction

  // run length minus one
  function automatic logic [LEN_W-1:0] run_last(input logic [31:0] d);
    return d[SRC_W+LEN_W-1:SRC_W];
  endfunction

  function automatic logic is_fill(input logic [SRC_W-1:0] s);
    return s == FILL_KEY;
  endfunction
endpackage

// File: rtl/blit_decode.sv
module blit_decode
  import blit_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CMD_W  = 64
) (
  input  logic [31:0]       cmd_addr,
  input  logic [CMD_W-1:0]  cmd_data,
  output logic [ADDR_W-1:0] dst,
  output logic [ADDR_W-1:0] src,
  output logic [LEN_W-1:0]  last,
  output logic              fill
);
  logic [31:0]      lo_word;
  logic [31:0]      dst_full;
  logic [SRC_W-1:0] src_full;
  logic             unused_bits;

  assign lo_word  = cmd_data[31:0];
  assign dst_full = dst_index(cmd_addr);
  assign src_full = src_field(lo_word);
  assign dst      = dst_full[ADDR_W-1:0];
  assign src      = src_full[ADDR_W-1:0];
  assign last     = run_last(lo_word);
  assign fill     = is_fill(src_full);

  generate
    if (CMD_W > 32) begin : g_wide
      assign unused_bits = ^{cmd_data[CMD_W-1:32], dst_full[31:ADDR_W], src_full[SRC_W-1:ADDR_W]};
    end else begin : g_narrow
      assign unused_bits = ^{dst_full[31:ADDR_W], src_full[SRC_W-1:ADDR_W]};
    end
  endgenerate
endmodule

// File: rtl/blit_colour_reg.sv
module blit_colour_reg #(
  parameter int FG_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [FG_W-1:0] value,
  output logic [FG_W-1:0] colour
);
  always_ff @(posedge clk) begin
    if (!rst_n)    colour <= '0;
    else if (load) colour <= value;
  end

  p_colour_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(colour));
endmodule

// File: rtl/blit_seq.sv
module blit_seq
  import blit_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int PIX_W  = 8,
  parameter int DEEP_W = 24,
  parameter int FG_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_wide,
  input  logic [ADDR_W-1:0] cmd_dst,
  input  logic [ADDR_W-1:0] cmd_src,
  input  logic [LEN_W-1:0]  cmd_last,
  input  logic              cmd_fill,
  input  logic [FG_W-1:0]   colour,
  output logic              idle,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [PIX_W-1:0]  mem_wdata,
  input  logic [PIX_W-1:0]  mem_rdata,
  output logic              pl_req,
  output logic              pl_we,
  output logic [DEEP_W-1:0] pl_wdata,
  input  logic [DEEP_W-1:0] pl_rdata
);
  seq_state_e        state_q;
  logic [ADDR_W-1:0] dst_q, src_q;
  logic [LEN_W-1:0]  idx_q, last_q;
  logic              wide_q;

  // named events for the checks below
  logic fill_beat, copy_rd, copy_wr, run_end;
  logic [ADDR_W-1:0] step;

  assign fill_beat = (state_q == S_FILL);
  assign copy_rd   = (state_q == S_RD);
  assign copy_wr   = (state_q == S_WR);
  assign run_end   = (fill_beat || copy_wr) && (idx_q == last_q);
  assign step      = ADDR_W'(idx_q);
  assign idle      = (state_q == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      dst_q   <= '0;
      src_q   <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      wide_q  <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start) begin
          dst_q   <= cmd_dst;
          src_q   <= cmd_src;
          last_q  <= cmd_last;
          idx_q   <= '0;
          wide_q  <= start_wide;
          state_q <= cmd_fill ? S_FILL : S_RD;
        end
        S_FILL: begin
          if (run_end) state_q <= S_IDLE;
          else         idx_q   <= idx_q + 1'b1;
        end
        S_RD: state_q <= S_WR;
        S_WR: begin
          if (run_end) state_q <= S_IDLE;
          else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= S_RD;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = !idle;
    mem_we    = fill_beat || copy_wr;
    mem_addr  = copy_rd ? (src_q + step) : (dst_q + step);
    mem_wdata = fill_beat ? colour[PIX_W-1:0] : mem_rdata;
    pl_req    = mem_req && wide_q;
    pl_we     = mem_we && wide_q;
    pl_wdata  = fill_beat ? colour[DEEP_W-1:0] : pl_rdata;
  end

  p_rd_then_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    copy_rd |=> (copy_wr && mem_we));
  p_fill_ascend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_beat && $past(fill_beat)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));
  p_wr_ascend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_wr && !run_end) |=> ##1 (copy_wr && mem_addr == ADDR_W'($past(mem_addr, 2) + 1'b1)));
  p_shadow_paired_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pl_req |-> (mem_req && pl_we == mem_we));
endmodule

// File: rtl/pix_blit_engine.sv
module pix_blit_engine
  import blit_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int PIX_W     = 8,
  parameter int DEEP_W    = 24,
  parameter int CMD_W     = 64,
  parameter int FG_W      = 32,
  parameter bit HAS_PLANE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_is_colour,
  input  logic [31:0]       cmd_addr,
  input  logic [CMD_W-1:0]  cmd_data,
  output logic [CMD_W-1:0]  cmd_rdata,
  input  logic              depth24,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [PIX_W-1:0]  mem_wdata,
  input  logic [PIX_W-1:0]  mem_rdata,
  output logic              pl_req,
  output logic              pl_we,
  output logic [DEEP_W-1:0] pl_wdata,
  input  logic [DEEP_W-1:0] pl_rdata
);
  logic              accept, run_go, colour_go, wide_go, idle;
  logic [ADDR_W-1:0] d_dst, d_src;
  logic [LEN_W-1:0]  d_last;
  logic              d_fill;
  logic [FG_W-1:0]   colour;
  logic              s_pl_req, s_pl_we;
  logic [DEEP_W-1:0] s_pl_wdata;

  assign cmd_ready = idle;
  assign busy      = !idle;
  assign cmd_rdata = '0;
  assign accept    = cmd_valid && cmd_ready;
  assign run_go    = accept && !cmd_is_colour;
  assign colour_go = accept && cmd_is_colour;

  blit_decode #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_dec (
    .cmd_addr (cmd_addr),
    .cmd_data (cmd_data),
    .dst      (d_dst),
    .src      (d_src),
    .last     (d_last),
    .fill     (d_fill)
  );

  blit_colour_reg #(.FG_W(FG_W)) u_fg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (colour_go),
    .value  (cmd_data[FG_W-1:0]),
    .colour (colour)
  );

  blit_seq #(.ADDR_W(ADDR_W), .PIX_W(PIX_W), .DEEP_W(DEEP_W), .FG_W(FG_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (run_go),
    .start_wide (wide_go),
    .cmd_dst    (d_dst),
    .cmd_src    (d_src),
    .cmd_last   (d_last),
    .cmd_fill   (d_fill),
    .colour     (colour),
    .idle       (idle),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .pl_req     (s_pl_req),
    .pl_we      (s_pl_we),
    .pl_wdata   (s_pl_wdata),
    .pl_rdata   (pl_rdata)
  );

  generate
    if (HAS_PLANE) begin : g_plane
      assign wide_go  = depth24;
      assign pl_req   = s_pl_req;
      assign pl_we    = s_pl_we;
      assign pl_wdata = s_pl_wdata;
    end else begin : g_no_plane
      logic unused_plane;
      assign unused_plane = ^{depth24, s_pl_req, s_pl_we, s_pl_wdata};
      assign wide_go  = 1'b0;
      assign pl_req   = 1'b0;
      assign pl_we    = 1'b0;
      assign pl_wdata = '0;
    end
  endgenerate

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !pl_req));
  p_ready_low_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);
  p_busy_after_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run_go |=> busy);
  p_colour_no_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    colour_go |=> !busy);
  p_no_shadow_narrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_go && !depth24) |=> !pl_req);
endmodule

// File: tb/pix_blit_engine_test.sv
module pix_blit_engine_test;
  localparam int MW = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_is_colour = 1'b0, depth24 = 1'b0;
  logic [31:0] cmd_addr = '0;
  logic [63:0] cmd_data = '0;
  logic        cmd_ready, busy, mem_req, mem_we, pl_req, pl_we;
  logic [63:0] cmd_rdata;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [23:0] pl_wdata, pl_rdata;

  logic [7:0]  m8 [MW];
  logic [23:0] m24[MW];
  logic [7:0]  r8 [MW];
  logic [23:0] r24[MW];
  logic [31:0] fg_model;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pix_blit_engine uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_is_colour(cmd_is_colour), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_rdata(cmd_rdata), .depth24(depth24), .busy(busy), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .pl_req(pl_req), .pl_we(pl_we), .pl_wdata(pl_wdata), .pl_rdata(pl_rdata)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) m8[mem_addr[11:0]] <= mem_wdata;
      else        mem_rdata <= m8[mem_addr[11:0]];
    end
    if (pl_req) begin
      if (pl_we) m24[mem_addr[11:0]] <= pl_wdata;
      else       pl_rdata <= m24[mem_addr[11:0]];
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference behaviour restated from the requirements
  function automatic int pix_of(input logic [31:0] a);
    return int'((a / 8) % (1 << 20));
  endfunction

  task automatic ref_run(input logic [31:0] a, input logic [63:0] d, input bit wide);
    int dst, src, n;
    dst = pix_of(a);
    src = int'(d[23:0]);
    n   = int'(d[28:24]) + 1;
    for (int i = 0; i < n; i++) begin
      int di, si;
      di = (dst + i) % MW;
      if (d[23:0] == 24'hFFFFFF) begin
        r8[di] = fg_model[7:0];
        if (wide) r24[di] = fg_model[23:0];
      end else begin
        si = ((src % (1 << 20)) + i) % MW;
        r8[di] = r8[si];
        if (wide) r24[di] = r24[si];
      end
    end
  endtask

  task automatic compare(input string req);
    int bad8, bad24, first;
    bad8 = 0; bad24 = 0; first = -1;
    for (int i = 0; i < MW; i++) begin
      if (m8[i] !== r8[i])   begin bad8++;  if (first < 0) first = i; end
      if (m24[i] !== r24[i]) begin bad24++; if (first < 0) first = i; end
    end
    if (first < 0) check(1'b1, req, 0, 0);
    else check(1'b0, req, {m8[first], m24[first]}, {r8[first], r24[first]});
  endtask

  task automatic send(input bit colour, input logic [31:0] a, input logic [63:0] d);
    cmd_valid = 1'b1; cmd_is_colour = colour; cmd_addr = a; cmd_data = d;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run(input logic [31:0] a, input logic [63:0] d, input string req);
    int cyc, expc;
    bit rdy_ok, wide;
    wide = depth24;
    send(1'b0, a, d);
    cyc = 0; rdy_ok = 1'b1;
    while (busy) begin
      cyc++;
      if (cmd_ready) rdy_ok = 1'b0;
      @(negedge clk);
    end
    expc = (d[23:0] == 24'hFFFFFF) ? int'(d[28:24]) + 1 : 2 * (int'(d[28:24]) + 1);
    check(cyc == expc, (d[23:0] == 24'hFFFFFF) ? "R4 busy length" : "R5 busy length", cyc, expc);
    check(rdy_ok, "R7 ready low while busy", !rdy_ok, 0);
    ref_run(a, d, wide);
    compare(req);
  endtask

  task automatic set_colour(input logic [31:0] c);
    send(1'b1, 32'h0, {32'hDEAD_BEEF, c});
    fg_model = c;
    check(!busy, "R7 colour write no busy", busy, 0);
  endtask

  function automatic logic [31:0] addr_for(input int pix, input logic [8:0] hi, input logic [2:0] lo);
    return {hi, 20'(pix), lo};
  endfunction

  function automatic logic [63:0] data_for(input logic [23:0] src, input int len, input logic [34:0] junk);
    return {junk[34:3], junk[2:0], 5'(len - 1), src};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd1234);
    for (int i = 0; i < MW; i++) begin
      m8[i] = 8'($urandom); m24[i] = 24'($urandom);
      r8[i] = m8[i]; r24[i] = m24[i];
    end
    fg_model = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cmd_ready && !busy && !mem_req && !pl_req, "R1 reset state",
          {cmd_ready, busy, mem_req, pl_req}, 4'b1000);
    check(cmd_rdata == '0, "R9 read zero", cmd_rdata, 0);

    // R8 fill before any colour write stores zero
    run(addr_for(100, 9'h0, 3'h0), data_for(24'hFFFFFF, 4, 35'h0), "R8 reset colour fill");

    // R4 fills of length 1 and 32, narrow mode
    set_colour(32'h00A1B2C3);
    run(addr_for(200, 9'h0, 3'h0), data_for(24'hFFFFFF, 1, 35'h0), "R4 fill len 1");
    run(addr_for(300, 9'h0, 3'h0), data_for(24'hFFFFFF, 32, 35'h0), "R4 fill len 32");

    // R2 R3 ignored address and data bits
    run(addr_for(400, 9'h1FF, 3'h7), data_for(24'hFFFFFF, 7, 35'h7_FFFF_FFFF), "R2 R3 ignored bits");

    // R5 overlapping copies in both directions
    run(addr_for(501, 9'h0, 3'h0), data_for(24'd500, 32, 35'h0), "R5 overlap dst above src");
    run(addr_for(600, 9'h0, 3'h0), data_for(24'd601, 32, 35'h0), "R5 overlap dst below src");
    run(addr_for(700, 9'h0, 3'h0), data_for(24'h0F_0123, 5, 35'h5_5555_5555), "R3 R5 copy high src bits");

    // R6 deep-colour fill and copy
    depth24 = 1'b1;
    set_colour(32'h7F123456);
    run(addr_for(800, 9'h0, 3'h0), data_for(24'hFFFFFF, 16, 35'h0), "R6 deep fill");
    run(addr_for(900, 9'h0, 3'h0), data_for(24'd795, 20, 35'h0), "R6 deep copy");
    depth24 = 1'b0;
    run(addr_for(1000, 9'h0, 3'h0), data_for(24'd800, 12, 35'h0), "R6 narrow copy leaves plane");

    // R10 depth captured at acceptance
    send(1'b0, addr_for(1100, 9'h0, 3'h0), data_for(24'hFFFFFF, 10, 35'h0));
    depth24 = 1'b1;
    while (busy) @(negedge clk);
    ref_run(addr_for(1100, 9'h0, 3'h0), data_for(24'hFFFFFF, 10, 35'h0), 1'b0);
    compare("R10 depth captured");
    depth24 = 1'b0;

    // R7 colour write offered mid-run waits
    send(1'b0, addr_for(1200, 9'h0, 3'h0), data_for(24'hFFFFFF, 20, 35'h0));
    ref_run(addr_for(1200, 9'h0, 3'h0), data_for(24'hFFFFFF, 20, 35'h0), 1'b0);
    send(1'b1, 32'h0, 64'h0000_0000_0055_6677);
    fg_model = 32'h0055_6677;
    compare("R7 held colour write");
    run(addr_for(1300, 9'h0, 3'h0), data_for(24'hFFFFFF, 6, 35'h0), "R7 new colour used");

    // random mix in a small window so runs overlap
    for (int k = 0; k < 60; k++) begin
      logic [31:0] a;
      logic [63:0] d;
      logic [23:0] s;
      depth24 = 1'($urandom);
      if (($urandom % 6) == 0) set_colour($urandom);
      a = addr_for(1500 + int'($urandom % 200), 9'($urandom), 3'($urandom));
      s = (($urandom % 4) == 0) ? 24'hFFFFFF : 24'(1500 + int'($urandom % 200));
      d = data_for(s, 1 + int'($urandom % 32), {3'($urandom), 32'($urandom)});
      run(a, d, "R4 R5 R6 random");
    end
    check(cmd_rdata == '0, "R9 read zero late", cmd_rdata, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule